// File: doc/BRIEF.md
# UART Register and Status Bank

This block is the register layer of a full-duplex serial port. A Wishbone slave port reaches four 32-bit words: status, control, received character and outgoing character. The control word drives the configuration of separate receive and transmit frontends: a clock divider, character size, parity mode and stop-bit count. Those frontends do the bit-level work; this block only stores, reports and hands over characters.

On the receive side, the frontend reports a completed frame with a one-cycle pulse. The pulse carries the character and its parity and framing error indications. The block latches the character, sets a not-empty flag and notes an overrun when the previous character was never read. Reading a register has side effects: reading the character clears it, and reading the status word clears the three error flags.

On the transmit side, a write of the outgoing word raises a valid/ready offer to the transmitter and holds it until the transmitter accepts it. Any control write that changes the stored value pulses a cancel line so both frontends abandon work in progress. The same change drops any character still waiting to be handed over.

Top module: `uart_regbank`

## Requirements
- R1: While rst_i is high and after its release, every register reads zero, wb_ack_o, cancel_o and tx_valid_o are low and all configuration outputs are zero.
- R2: Word offsets are status 0x0, control 0x4, received character 0x8 and outgoing character 0xC (wb_adr_i[3:2]). Every access with wb_cyc_i and wb_stb_i high is acknowledged for exactly one cycle, one cycle after it is taken. The outgoing-character offset reads zero. Writes to the status and received-character offsets change nothing.
- R3: The control word keeps bits [19:0] and reads the rest as zero. Its fields are clock divider [15:0] on clk_div_o, character size bit 16 on data8_o (0 = 7 bits, 1 = 8 bits), parity [18:17] on parity_o (00 none, 01 even, 10 odd) and stop bits bit 19 on stop2_o (0 one, 1 two).
- R4: A control write whose kept value differs from the stored one pulses cancel_o for one cycle, in the cycle after the write is taken. In that same cycle it withdraws any pending outgoing character (tx_valid_o low). A write of an equal value does neither.
- R5: A rx_done_i pulse loads rx_data_i into the received-character word and sets status bit 0 (not-empty) in the same edge. In 7-bit mode, bit 7 of the stored character is zero.
- R6: Reading the received-character word returns its content, then clears the word to zero and clears status bit 0.
- R7: A frame pulse with rx_perr_i sets status bit 4 (parity error), and one with rx_ferr_i sets status bit 3 (framing error). A status read returns these flags and then clears them. A status read does not clear bit 0.
- R8: Status bit 2 (overrun) is set when a frame pulse arrives while bit 0 is set and the received-character word is not being read in that cycle. The newest character replaces the old one. A status read clears bit 2.
- R9: When a flag set and a clearing read fall in the same cycle, the set wins and the read returns the value from before that edge.
- R10: A write to the outgoing word while the transmitter is idle raises tx_valid_o with tx_data_o equal to the written character on the next cycle. Both hold until a cycle with tx_ready_i high. Status bit 1 (busy) reads tx_valid_o OR tx_busy_i.
- R11: A write to the outgoing word while tx_valid_o or tx_busy_i is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | DATA_W | Write data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_dat_o | output | DATA_W | Read data |
| clk_div_o | output | DIV_W | Bit period in clock cycles |
| data8_o | output | 1 | Eight-bit characters when high |
| parity_o | output | 2 | Parity mode |
| stop2_o | output | 1 | Two stop bits when high |
| cancel_o | output | 1 | Abort pulse to both frontends |
| rx_done_i | input | 1 | Receiver frame complete pulse |
| rx_data_i | input | CHAR_W | Received character |
| rx_perr_i | input | 1 | Parity error with the frame |
| rx_ferr_i | input | 1 | Framing error with the frame |
| tx_valid_o | output | 1 | Outgoing character offered |
| tx_data_o | output | CHAR_W | Outgoing character |
| tx_ready_i | input | 1 | Transmitter takes the character |
| tx_busy_i | input | 1 | Transmitter is serialising |

## Verification
Two pairs of events can land on one clock edge: a frame completion and a read of the received character, and a frame carrying an error and a status read. The bench drives the frame pulse and the bus strobe in the same cycle for each pair. It then judges three results: the value the read returned (the old content), whether the flag survived on a follow-up status read, and whether overrun stayed clear because the old character counted as consumed.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

   typedef enum logic [1:0] {
      REG_STAT = 2'd0,
      REG_CTRL = 2'd1,
      REG_RXD  = 2'd2,
      REG_TXD  = 2'd3
   } reg_sel_e;

   localparam int NUM_REGS  = 4;
   localparam int STAT_RXNE = 0;
   localparam int STAT_BUSY = 1;
   localparam int STAT_OVR  = 2;
   localparam int STAT_FERR = 3;
   localparam int STAT_PERR = 4;
   localparam int STAT_W    = 5;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ODD  = 2'b10
   } parity_e;

endpackage

// File: rtl/uart_rb_bus.sv
module uart_rb_bus
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic                             clk_i,
   input  logic                             rst_i,
   input  logic                             cyc_i,
   input  logic                             stb_i,
   input  logic                             we_i,
   input  logic [ADDR_W-1:0]                adr_i,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  rd_vals_i,
   output logic [NUM_REGS-1:0]              wr_hit_o,
   output logic [NUM_REGS-1:0]              rd_hit_o,
   output logic                             ack_o,
   output logic [DATA_W-1:0]                dat_o
);

   logic             ack_q;
   logic [DATA_W-1:0] dat_q;
   logic             take;
   logic             in_range;
   logic [1:0]       word;
   wire              unused_lo = ^adr_i[1:0];

   assign take = cyc_i & stb_i & ~ack_q;
   assign word = adr_i[3:2];

   generate
      if (ADDR_W > 4) begin : g_wide_adr
         assign in_range = ~|adr_i[ADDR_W-1:4];
      end else begin : g_narrow_adr
         assign in_range = 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_decode
         logic hit;
         assign hit         = take & in_range & (word == g[1:0]);
         assign wr_hit_o[g] = hit & we_i;
         assign rd_hit_o[g] = hit & ~we_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_q <= 1'b0;
         dat_q <= '0;
      end else begin
         ack_q <= take;
         if (take) begin
            dat_q <= (!we_i && in_range) ? rd_vals_i[word] : '0;
         end
      end
   end

   assign ack_o = ack_q;
   assign dat_o = dat_q;

endmodule

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl #(
   parameter int DIV_W  = 16,
   parameter int CTRL_W = DIV_W + 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              change_o,
   output logic              cancel_o
);

   logic [CTRL_W-1:0] ctrl_q;
   logic              cancel_q;

   assign change_o = wr_i & (wdata_i != ctrl_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ctrl_q   <= '0;
         cancel_q <= 1'b0;
      end else begin
         cancel_q <= change_o;
         if (wr_i) begin
            ctrl_q <= wdata_i;
         end
      end
   end

   assign ctrl_o   = ctrl_q;
   assign cancel_o = cancel_q;

endmodule

// File: rtl/uart_rb_rx.sv
module uart_rb_rx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              done_i,
   input  logic [CHAR_W-1:0] data_i,
   input  logic              perr_i,
   input  logic              ferr_i,
   input  logic              full_char_i,
   input  logic              rd_data_i,
   input  logic              rd_stat_i,
   output logic [CHAR_W-1:0] rxd_o,
   output logic              rxne_o,
   output logic              ovr_o,
   output logic              ferr_o,
   output logic              perr_o
);

   localparam logic [CHAR_W-1:0] MASK_FULL  = '1;
   localparam logic [CHAR_W-1:0] MASK_SHORT = MASK_FULL >> 1;

   logic [CHAR_W-1:0] rxd_q;
   logic              rxne_q, ovr_q, ferr_q, perr_q;
   logic [CHAR_W-1:0] mask;
   logic              overrun;

   assign mask    = full_char_i ? MASK_FULL : MASK_SHORT;
   assign overrun = done_i & rxne_q & ~rd_data_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rxd_q  <= '0;
         rxne_q <= 1'b0;
      end else if (done_i) begin
         rxd_q  <= data_i & mask;
         rxne_q <= 1'b1;
      end else if (rd_data_i) begin
         rxd_q  <= '0;
         rxne_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ovr_q  <= 1'b0;
         ferr_q <= 1'b0;
         perr_q <= 1'b0;
      end else begin
         if (overrun)              ovr_q  <= 1'b1;
         else if (rd_stat_i)       ovr_q  <= 1'b0;
         if (done_i && ferr_i)     ferr_q <= 1'b1;
         else if (rd_stat_i)       ferr_q <= 1'b0;
         if (done_i && perr_i)     perr_q <= 1'b1;
         else if (rd_stat_i)       perr_q <= 1'b0;
      end
   end

   assign rxd_o  = rxd_q;
   assign rxne_o = rxne_q;
   assign ovr_o  = ovr_q;
   assign ferr_o = ferr_q;
   assign perr_o = perr_q;

endmodule

// File: rtl/uart_rb_tx.sv
module uart_rb_tx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic [CHAR_W-1:0] wdata_i,
   input  logic              abort_i,
   input  logic              ready_i,
   input  logic              busy_i,
   output logic              valid_o,
   output logic [CHAR_W-1:0] data_o
);

   logic              valid_q;
   logic [CHAR_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (abort_i) begin
         valid_q <= 1'b0;
      end else if (valid_q && ready_i) begin
         valid_q <= 1'b0;
      end else if (wr_i && !valid_q && !busy_i) begin
         valid_q <= 1'b1;
         data_q  <= wdata_i;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int DIV_W  = 16,
   parameter int CHAR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic              wb_ack_o,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic [DIV_W-1:0]  clk_div_o,
   output logic              data8_o,
   output logic [1:0]        parity_o,
   output logic              stop2_o,
   output logic              cancel_o,
   input  logic              rx_done_i,
   input  logic [CHAR_W-1:0] rx_data_i,
   input  logic              rx_perr_i,
   input  logic              rx_ferr_i,
   output logic              tx_valid_o,
   output logic [CHAR_W-1:0] tx_data_o,
   input  logic              tx_ready_i,
   input  logic              tx_busy_i
);

   localparam int CTRL_W   = DIV_W + 4;
   localparam int POS_SIZE = DIV_W;
   localparam int POS_PAR  = DIV_W + 1;
   localparam int POS_STOP = DIV_W + 3;

   generate
      if (ADDR_W < 4) begin : g_chk_addr
         $error("uart_regbank: ADDR_W must cover four word offsets");
      end
      if (CTRL_W >= DATA_W) begin : g_chk_ctrl
         $error("uart_regbank: control fields exceed the data width");
      end
      if (CHAR_W < 2 || CHAR_W > DATA_W) begin : g_chk_char
         $error("uart_regbank: CHAR_W out of range");
      end
   endgenerate

   logic [NUM_REGS-1:0]             wr_hit, rd_hit;
   logic [NUM_REGS-1:0][DATA_W-1:0] rd_vals;
   logic [CTRL_W-1:0]               ctrl_w;
   logic                            ctrl_change;
   logic [CHAR_W-1:0]               rxd_w;
   logic                            rxne_w, ovr_w, ferr_w, perr_w;
   logic                            rd_rxd_w;
   logic [STAT_W-1:0]               stat_w;
   wire                             unused_hi = ^wb_dat_i[DATA_W-1:CTRL_W];

   uart_rb_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cyc_i     (wb_cyc_i),
      .stb_i     (wb_stb_i),
      .we_i      (wb_we_i),
      .adr_i     (wb_adr_i),
      .rd_vals_i (rd_vals),
      .wr_hit_o  (wr_hit),
      .rd_hit_o  (rd_hit),
      .ack_o     (wb_ack_o),
      .dat_o     (wb_dat_o)
   );

   uart_rb_ctrl #(.DIV_W(DIV_W), .CTRL_W(CTRL_W)) u_ctrl (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_i     (wr_hit[REG_CTRL]),
      .wdata_i  (wb_dat_i[CTRL_W-1:0]),
      .ctrl_o   (ctrl_w),
      .change_o (ctrl_change),
      .cancel_o (cancel_o)
   );

   assign rd_rxd_w = rd_hit[REG_RXD];

   uart_rb_rx #(.CHAR_W(CHAR_W)) u_rx (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .done_i      (rx_done_i),
      .data_i      (rx_data_i),
      .perr_i      (rx_perr_i),
      .ferr_i      (rx_ferr_i),
      .full_char_i (ctrl_w[POS_SIZE]),
      .rd_data_i   (rd_rxd_w),
      .rd_stat_i   (rd_hit[REG_STAT]),
      .rxd_o       (rxd_w),
      .rxne_o      (rxne_w),
      .ovr_o       (ovr_w),
      .ferr_o      (ferr_w),
      .perr_o      (perr_w)
   );

   uart_rb_tx #(.CHAR_W(CHAR_W)) u_tx (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_i    (wr_hit[REG_TXD]),
      .wdata_i (wb_dat_i[CHAR_W-1:0]),
      .abort_i (ctrl_change),
      .ready_i (tx_ready_i),
      .busy_i  (tx_busy_i),
      .valid_o (tx_valid_o),
      .data_o  (tx_data_o)
   );

   always_comb begin
      stat_w            = '0;
      stat_w[STAT_RXNE] = rxne_w;
      stat_w[STAT_BUSY] = tx_valid_o | tx_busy_i;
      stat_w[STAT_OVR]  = ovr_w;
      stat_w[STAT_FERR] = ferr_w;
      stat_w[STAT_PERR] = perr_w;
   end

   assign rd_vals[REG_STAT] = {{(DATA_W-STAT_W){1'b0}}, stat_w};
   assign rd_vals[REG_CTRL] = {{(DATA_W-CTRL_W){1'b0}}, ctrl_w};
   assign rd_vals[REG_RXD]  = {{(DATA_W-CHAR_W){1'b0}}, rxd_w};
   assign rd_vals[REG_TXD]  = '0;

   assign clk_div_o = ctrl_w[DIV_W-1:0];
   assign data8_o   = ctrl_w[POS_SIZE];
   assign parity_o  = ctrl_w[POS_PAR+1:POS_PAR];
   assign stop2_o   = ctrl_w[POS_STOP];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wb_cyc_i,
   input logic              wb_stb_i,
   input logic              wb_ack_o,
   input logic              cancel_o,
   input logic              tx_valid_o,
   input logic              tx_ready_i,
   input logic [CHAR_W-1:0] tx_data_o,
   input logic              rx_done_i,
   input logic              rxne,
   input logic              ovr,
   input logic              rd_rxd
);

   AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
      (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o); // R2
   AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      wb_ack_o |=> !wb_ack_o); // R2
   AST_CANCEL_DROPS_TX: assert property (@(posedge clk_i) disable iff (rst_i)
      cancel_o |-> !tx_valid_o); // R4
   AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (tx_valid_o && !tx_ready_i) |=> (cancel_o || (tx_valid_o && $stable(tx_data_o)))); // R10
   AST_RXNE_ON_FRAME: assert property (@(posedge clk_i) disable iff (rst_i)
      rx_done_i |=> rxne); // R5
   AST_OVR_SET: assert property (@(posedge clk_i) disable iff (rst_i)
      (rx_done_i && rxne && !rd_rxd) |=> ovr); // R8
   AST_OVR_ONLY_FRAME: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ovr && !rx_done_i) |=> !ovr); // R8

endmodule

bind uart_regbank uart_regbank_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .wb_cyc_i   (wb_cyc_i),
   .wb_stb_i   (wb_stb_i),
   .wb_ack_o   (wb_ack_o),
   .cancel_o   (cancel_o),
   .tx_valid_o (tx_valid_o),
   .tx_ready_i (tx_ready_i),
   .tx_data_o  (tx_data_o),
   .rx_done_i  (rx_done_i),
   .rxne       (rxne_w),
   .ovr        (ovr_w),
   .rd_rxd     (rd_rxd_w)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;

   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_STAT = 4'h0;
   localparam logic [3:0] A_CTRL = 4'h4;
   localparam logic [3:0] A_RXD  = 4'h8;
   localparam logic [3:0] A_TXD  = 4'hC;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [3:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic        ack;
   logic [31:0] rdat;
   logic [15:0] clk_div;
   logic        data8, stop2, cancel;
   logic [1:0]  parity;
   logic        rx_done = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        tx_valid, tx_ready = 1'b0, tx_busy = 1'b0;
   logic [7:0]  tx_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] r;
   logic        a, c;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_regbank u0 (
      .clk_i(clk), .rst_i(rst),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat),
      .wb_ack_o(ack), .wb_dat_o(rdat),
      .clk_div_o(clk_div), .data8_o(data8), .parity_o(parity), .stop2_o(stop2),
      .cancel_o(cancel),
      .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready), .tx_busy_i(tx_busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // one bus access, optionally with a frame pulse in the same cycle
   task automatic access(input logic w, input logic [3:0] ad, input logic [31:0] d,
                         input logic frame, input logic [7:0] fd,
                         input logic fpe, input logic ffe,
                         output logic [31:0] rd, output logic ak, output logic cn);
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = w; adr = ad; wdat = d;
      rx_done = frame; rx_data = fd; rx_perr = fpe; rx_ferr = ffe;
      @(negedge clk);
      rd = rdat; ak = ack; cn = cancel;
      cyc = 1'b0; stb = 1'b0; we = 1'b0; rx_done = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] ad, output logic [31:0] v);
      logic ak, cn;
      access(1'b0, ad, 32'h0, 1'b0, 8'h0, 1'b0, 1'b0, v, ak, cn);
   endtask

   task automatic wr_reg(input logic [3:0] ad, input logic [31:0] d, output logic cn);
      logic [31:0] v;
      logic ak;
      access(1'b1, ad, d, 1'b0, 8'h0, 1'b0, 1'b0, v, ak, cn);
   endtask

   task automatic frame(input logic [7:0] d, input logic pe, input logic fe);
      @(negedge clk);
      rx_done = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe;
      @(negedge clk);
      rx_done = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] prev;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 ack in reset", {31'b0, ack}, 32'h0);
      check("R1 tx_valid in reset", {31'b0, tx_valid}, 32'h0);
      check("R1 config in reset", {12'b0, stop2, parity, data8, clk_div}, 32'h0);
      rst = 1'b0;
      check("R1 cancel after reset", {31'b0, cancel}, 32'h0);
      rd_reg(A_STAT, r); check("R1 status zero", r, 32'h0);
      rd_reg(A_CTRL, r); check("R1 control zero", r, 32'h0);
      rd_reg(A_RXD, r);  check("R1 rx char zero", r, 32'h0);

      // R2: acknowledge timing and read-only offsets
      access(1'b0, A_STAT, 32'h0, 1'b0, 8'h0, 1'b0, 1'b0, r, a, c);
      check("R2 ack one cycle after strobe", {31'b0, a}, 32'h1);
      @(negedge clk);
      check("R2 ack single cycle", {31'b0, ack}, 32'h0);
      wr_reg(A_STAT, 32'hFFFF_FFFF, c);
      wr_reg(A_RXD, 32'hFFFF_FFFF, c);
      rd_reg(A_STAT, r); check("R2 status write ignored", r, 32'h0);
      rd_reg(A_RXD, r);  check("R2 rx char write ignored", r, 32'h0);
      rd_reg(A_TXD, r);  check("R2 tx offset reads zero", r, 32'h0);

      // R3/R4: control sweep
      prev = 32'h0;
      for (int i = 0; i < 24; i++) begin
         logic [31:0] v, m;
         v = (i % 5 == 4) ? prev : (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << i);
         m = v & 32'h000F_FFFF;
         wr_reg(A_CTRL, v, c);
         check("R4 cancel pulse on change", {31'b0, c}, {31'b0, (m != prev)});
         rd_reg(A_CTRL, r);
         check("R3 control readback", r, m);
         check("R3 clk_div field", {16'b0, clk_div}, {16'b0, m[15:0]});
         check("R3 size/parity/stop fields", {28'b0, stop2, parity, data8}, {28'b0, m[19:16]});
         check("R4 cancel is one cycle", {31'b0, cancel}, 32'h0);
         prev = m;
      end

      // R5/R6/R7: 8-bit receive sweep
      wr_reg(A_CTRL, 32'h0001_0004, c);
      for (int v = 0; v < 256; v++) begin
         logic pe, fe;
         pe = v[0]; fe = v[1];
         frame(v[7:0], pe, fe);
         rd_reg(A_STAT, r);
         check("R7 error flags and not-empty", r, {27'b0, pe, fe, 3'b001});
         rd_reg(A_STAT, r);
         check("R7 flags cleared by status read", r, 32'h1);
         rd_reg(A_RXD, r);
         check("R5 character loaded", r, {24'b0, v[7:0]});
         rd_reg(A_STAT, r);
         check("R6 not-empty cleared", r, 32'h0);
         rd_reg(A_RXD, r);
         check("R6 rx char cleared", r, 32'h0);
      end

      // R5: 7-bit mode masks the top bit
      wr_reg(A_CTRL, 32'h0000_0004, c);
      for (int v = 0; v < 256; v += 17) begin
         frame(v[7:0], 1'b0, 1'b0);
         rd_reg(A_RXD, r);
         check("R5 seven-bit character", r, {24'b0, 1'b0, v[6:0]});
      end

      // R8: overrun
      frame(8'h21, 1'b0, 1'b0);
      frame(8'h42, 1'b0, 1'b0);
      rd_reg(A_STAT, r); check("R8 overrun flagged", r, 32'h5);
      rd_reg(A_STAT, r); check("R8 overrun cleared by read", r, 32'h1);
      rd_reg(A_RXD, r);  check("R8 newest character kept", r, 32'h42);

      // R9: frame completes in the cycle its predecessor is read
      frame(8'h13, 1'b0, 1'b0);
      access(1'b0, A_RXD, 32'h0, 1'b1, 8'h57, 1'b0, 1'b0, r, a, c);
      check("R9 read returns old character", r, 32'h13);
      rd_reg(A_STAT, r); check("R9 not-empty kept, R8 no overrun", r, 32'h1);
      rd_reg(A_RXD, r);  check("R9 new character stored", r, 32'h57);

      // R9: error frame in the cycle of a status read
      access(1'b0, A_STAT, 32'h0, 1'b1, 8'h66, 1'b1, 1'b1, r, a, c);
      check("R9 status read returns prior value", r, 32'h0);
      rd_reg(A_STAT, r); check("R9 error flags survive", r, 32'h19);
      rd_reg(A_RXD, r);  check("R9 character with errors", r, 32'h66);

      // R10/R11: transmit hand-off sweep
      for (int v = 0; v < 256; v += 5) begin
         wr_reg(A_TXD, 32'hABCD_0000 | v, c);
         check("R10 offer raised", {31'b0, tx_valid}, 32'h1);
         check("R10 offered character", {24'b0, tx_data}, {24'b0, v[7:0]});
         rd_reg(A_STAT, r); check("R10 busy while offered", r, 32'h2);
         wr_reg(A_TXD, {24'b0, ~v[7:0]}, c);
         check("R11 write while pending ignored", {24'b0, tx_data}, {24'b0, v[7:0]});
         check("R10 offer held", {31'b0, tx_valid}, 32'h1);
         @(negedge clk); tx_ready = 1'b1;
         @(negedge clk); tx_ready = 1'b0;
         check("R10 offer taken", {31'b0, tx_valid}, 32'h0);
      end
      tx_busy = 1'b1;
      wr_reg(A_TXD, 32'h5A, c);
      check("R11 write while frontend busy ignored", {31'b0, tx_valid}, 32'h0);
      rd_reg(A_STAT, r); check("R10 busy from frontend", r, 32'h2);
      tx_busy = 1'b0;
      rd_reg(A_STAT, r); check("R10 idle status", r, 32'h0);

      // R4: control changes and pending offers
      wr_reg(A_TXD, 32'h3C, c);
      wr_reg(A_CTRL, 32'h0000_0004, c);
      check("R4 equal write no cancel", {31'b0, c}, 32'h0);
      check("R4 equal write keeps offer", {31'b0, tx_valid}, 32'h1);
      wr_reg(A_CTRL, 32'h0009_0010, c);
      check("R4 change cancels", {31'b0, c}, 32'h1);
      check("R4 change withdraws offer", {31'b0, tx_valid}, 32'h0);

      finish_run();
   end

endmodule